// File: doc/BRIEF.md
# UART Handshake Register Front End

This block is the memory-mapped register layer that sits between a host bus and the character FIFOs of a UART. The UART carries 8-bit characters with one stop bit and a selectable parity. All character traffic goes through a single data word. Each direction has its own handshake flag in that word. On a read, the flags report whether the transmit side can take a character and whether a received character is waiting. On a write, a set flag pushes a character to the transmit FIFO or pops the received one. The serializer and deserializer are outside the block; it only sees their FIFO push/pop strobes, full/empty flags and the raw serial output.

A control word holds the parity selection, an interface-mode field, a line-break request and a master enable for the host interrupt. It also shows a read-only busy flag and the pending-interrupt flag. Two event sources, received-data-valid and transmit-FIFO-empty, latch into a status word. Software clears a status bit by writing 1 to it. An enable word masks the status bits, and the host interrupt line is raised when the masked status is non-zero and the master enable is set.

Top module: `uart_hs_regs`

## Requirements
- R1: After reset the control word, interrupt status word and interrupt enable word read 0, and `host_irq`, `tx_push` and `rx_pop` are low.
- R2: A write to the data word (address 0) with bit 8 set while `tx_full` is low raises `tx_push` for that cycle with `tx_data` equal to write bits [7:0]. A write with bit 8 clear, or with `tx_full` high, does not push.
- R3: On a data-word read, bit 8 reads 1 exactly when `tx_full` is low.
- R4: On a data-word read, bit 9 reads 1 exactly when `rx_empty` is low. Bits [7:0] show `rx_data` in that case and read 0 otherwise.
- R5: A data-word write with bit 9 set raises `rx_pop` for that cycle when `rx_empty` is low. Such a write never pops while `rx_empty` is high.
- R6: Interrupt status bit 0 (receive valid) is set at the first clock edge that samples `rx_empty` low after it was high. Status bit 1 (transmit empty) is set at the first clock edge that samples `tx_empty` high after it was low.
- R7: Writing the interrupt status word (address 2) clears each bit written as 1 and leaves bits written as 0 unchanged. A source event in the same cycle as its clear leaves the bit set.
- R8: The interrupt enable word is address 3, bits [1:0]. Control bit 6 reads 1 when status AND enable is non-zero. `host_irq` is high exactly when that holds and control bit 5 (host interrupt enable) is 1.
- R9: Control bit 4 (break) drives `tx_break`. While it is 1, `txd` is 0; otherwise `txd` follows `ser_out_raw`.
- R10: Control bit 7 reads 1 while `tx_empty` is low or `tx_active` is high. Writes to bits 6 and 7 have no effect.
- R11: Control bits [1:0] select parity, with 0 none, 1 even and 2 odd, and drive `parity_mode`. A write of code 3 leaves the field unchanged. Control bits [3:2] are a read/write interface-mode field that drives `if_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| tx_push | output | 1 | Push strobe to transmit FIFO |
| tx_data | output | 8 | Character to push |
| tx_full | input | 1 | Transmit FIFO full |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_active | input | 1 | A frame is still shifting out |
| rx_pop | output | 1 | Pop strobe to receive FIFO |
| rx_data | input | 8 | Receive FIFO head character |
| rx_empty | input | 1 | Receive FIFO empty |
| ser_out_raw | input | 1 | Serializer output before break forcing |
| txd | output | 1 | Serial line output |
| tx_break | output | 1 | Break request to transmitter |
| parity_mode | output | 2 | Parity selection |
| if_mode | output | 2 | Interface-mode field |
| host_irq | output | 1 | Host interrupt line |

## Verification
The data word is exercised by writes with only the transmit flag, only the receive flag, and neither flag, each against full/non-full and empty/non-empty FIFO states. These writes separate a correct handshake gate from one that ignores the FIFO flags or the wrong bit. The interrupt path is driven by FIFO level edges in both directions, by clears of the wrong bit and of the right bit, and by a clear that lands in the same cycle as a new event. This shows whether the block latches on edges, clears per bit and gives the event priority. Control writes carry the reserved parity code and attempts on the read-only bits, with the busy flag checked under each combination of FIFO-empty and shifting.

// File: rtl/uart_hs_pkg.sv
package uart_hs_pkg;
   // word addresses
   localparam logic [1:0] ADR_DATA  = 2'd0;
   localparam logic [1:0] ADR_CTRL  = 2'd1;
   localparam logic [1:0] ADR_ISTAT = 2'd2;
   localparam logic [1:0] ADR_IEN   = 2'd3;

   // control word bit positions
   localparam int CB_PAR  = 0;
   localparam int CB_MODE = 2;
   localparam int CB_BRK  = 4;
   localparam int CB_HEN  = 5;
   localparam int CB_PEND = 6;
   localparam int CB_BUSY = 7;
   localparam int CTRL_W  = 8;

   // interrupt sources
   localparam int NSRC   = 2;
   localparam int SRC_RX = 0;
   localparam int SRC_TX = 1;

   typedef enum logic [1:0] {
      PAR_NONE = 2'd0,
      PAR_EVEN = 2'd1,
      PAR_ODD  = 2'd2,
      PAR_RSVD = 2'd3
   } par_e;
endpackage

// File: rtl/uart_hs_evt.sv
module uart_hs_evt #(
   parameter bit RESET_LEVEL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   input  logic clr,
   output logic flag
);
   logic level_q;
   logic evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_q <= RESET_LEVEL;
      else        level_q <= level;
   end

   assign evt = level & ~level_q;

   // an event outranks a same-cycle clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag <= 1'b0;
      else if (evt) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
   end

   assert_set_on_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> flag);
   assert_w1c_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !evt) |=> !flag);
   assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt && !clr) |=> $stable(flag));
endmodule

// File: rtl/uart_hs_ctrl.sv
module uart_hs_ctrl
   import uart_hs_pkg::*;
#(
   parameter bit REJECT_RSVD_PAR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [CTRL_W-1:0] wval,
   output logic [1:0]        par,
   output logic [1:0]        mode,
   output logic              brk,
   output logic              hen
);
   logic [1:0] par_next;
   logic [1:0] w_par;
   logic       unused_ro;

   assign w_par     = wval[CB_PAR +: 2];
   assign unused_ro = ^wval[CTRL_W-1:CB_PEND];

   generate
      if (REJECT_RSVD_PAR) begin : g_rej
         assign par_next = (w_par == PAR_RSVD) ? par : w_par;
         assert_par_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
            par != PAR_RSVD);
      end else begin : g_keep
         assign par_next = w_par;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         par  <= PAR_NONE;
         mode <= 2'd0;
         brk  <= 1'b0;
         hen  <= 1'b0;
      end else if (wr) begin
         par  <= par_next;
         mode <= wval[CB_MODE +: 2];
         brk  <= wval[CB_BRK];
         hen  <= wval[CB_HEN];
      end
   end
endmodule

// File: rtl/uart_hs_regs.sv
module uart_hs_regs
   import uart_hs_pkg::*;
#(
   parameter int DATA_W          = 8,
   parameter int ADDR_W          = 2,
   parameter int BUS_W           = 32,
   parameter bit REJECT_RSVD_PAR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              tx_push,
   output logic [DATA_W-1:0] tx_data,
   input  logic              tx_full,
   input  logic              tx_empty,
   input  logic              tx_active,
   output logic              rx_pop,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_empty,
   input  logic              ser_out_raw,
   output logic              txd,
   output logic              tx_break,
   output logic [1:0]        parity_mode,
   output logic [1:0]        if_mode,
   output logic              host_irq
);
   localparam int DB_TXRDY = DATA_W;
   localparam int DB_RXVLD = DATA_W + 1;

   generate
      if (BUS_W < DATA_W + 2 || BUS_W < CTRL_W) begin : g_bad_bus
         $error("bus width too narrow for data word and flags");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("address width must cover four words");
      end
   endgenerate

   logic            wr_any, wr_data, wr_ctrl, wr_istat, wr_ien;
   logic [NSRC-1:0] istat, ien, src_lvl;
   logic            pend, ctl_hen, ctl_brk;
   logic [1:0]      ctl_par, ctl_mode;
   logic            unused_hi;

   assign unused_hi = ^bus_wdata[BUS_W-1:DATA_W+2];

   assign wr_any   = bus_sel & bus_wr;
   assign wr_data  = wr_any & (bus_addr == ADDR_W'(ADR_DATA));
   assign wr_ctrl  = wr_any & (bus_addr == ADDR_W'(ADR_CTRL));
   assign wr_istat = wr_any & (bus_addr == ADDR_W'(ADR_ISTAT));
   assign wr_ien   = wr_any & (bus_addr == ADDR_W'(ADR_IEN));

   // character handshake
   assign tx_push = wr_data & bus_wdata[DB_TXRDY] & ~tx_full;
   assign tx_data = bus_wdata[DATA_W-1:0];
   assign rx_pop  = wr_data & bus_wdata[DB_RXVLD] & ~rx_empty;

   uart_hs_ctrl #(.REJECT_RSVD_PAR(REJECT_RSVD_PAR)) u_ctrl (
      .clk  (clk),
      .rst_n(rst_n),
      .wr   (wr_ctrl),
      .wval (bus_wdata[CTRL_W-1:0]),
      .par  (ctl_par),
      .mode (ctl_mode),
      .brk  (ctl_brk),
      .hen  (ctl_hen)
   );

   // interrupt sources: receive data appears, transmit FIFO drains
   assign src_lvl[SRC_RX] = ~rx_empty;
   assign src_lvl[SRC_TX] = tx_empty;

   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_src
         uart_hs_evt #(.RESET_LEVEL(i == SRC_TX)) u_evt (
            .clk  (clk),
            .rst_n(rst_n),
            .level(src_lvl[i]),
            .clr  (wr_istat & bus_wdata[i]),
            .flag (istat[i])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ien <= '0;
      else if (wr_ien) ien <= bus_wdata[NSRC-1:0];
   end

   assign pend     = |(istat & ien);
   assign host_irq = ctl_hen & pend;

   assign tx_break    = ctl_brk;
   assign txd         = ctl_brk ? 1'b0 : ser_out_raw;
   assign parity_mode = ctl_par;
   assign if_mode     = ctl_mode;

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(ADR_DATA): begin
            bus_rdata[DATA_W-1:0] = rx_empty ? '0 : rx_data;
            bus_rdata[DB_TXRDY]   = ~tx_full;
            bus_rdata[DB_RXVLD]   = ~rx_empty;
         end
         ADDR_W'(ADR_CTRL): begin
            bus_rdata[CB_PAR +: 2]  = ctl_par;
            bus_rdata[CB_MODE +: 2] = ctl_mode;
            bus_rdata[CB_BRK]       = ctl_brk;
            bus_rdata[CB_HEN]       = ctl_hen;
            bus_rdata[CB_PEND]      = pend;
            bus_rdata[CB_BUSY]      = ~tx_empty | tx_active;
         end
         ADDR_W'(ADR_ISTAT): bus_rdata[NSRC-1:0] = istat;
         ADDR_W'(ADR_IEN):   bus_rdata[NSRC-1:0] = ien;
         default:            bus_rdata = '0;
      endcase
   end

   assert_no_push_when_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_full |-> !tx_push);
   assert_no_pop_when_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_empty |-> !rx_pop);
   assert_break_forces_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_break && ser_out_raw) |-> !txd);
   assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      host_irq |-> (ctl_hen && (istat != '0)));
endmodule

// File: tb/uart_hs_regs_test.sv
module uart_hs_regs_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        tx_push, rx_pop, txd, tx_break, host_irq;
   logic [7:0]  tx_data;
   logic        tx_full = 1'b0, tx_empty = 1'b1, tx_active = 1'b0;
   logic [7:0]  rx_data = 8'h00;
   logic        rx_empty = 1'b1, ser_out_raw = 1'b1;
   logic [1:0]  parity_mode, if_mode;

   int checks = 0;
   int errors = 0;
   logic        s_push, s_pop;
   logic [7:0]  s_tdata;
   logic [31:0] rd;

   always #2 clk = ~clk;

   uart_hs_regs uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tx_push(tx_push), .tx_data(tx_data), .tx_full(tx_full),
      .tx_empty(tx_empty), .tx_active(tx_active), .rx_pop(rx_pop),
      .rx_data(rx_data), .rx_empty(rx_empty), .ser_out_raw(ser_out_raw),
      .txd(txd), .tx_break(tx_break), .parity_mode(parity_mode),
      .if_mode(if_mode), .host_irq(host_irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // write: inputs set at a falling edge, strobes sampled before the rising edge
   task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      #1;
      s_push = tx_push; s_pop = rx_pop; s_tdata = tx_data;
      @(posedge clk);
      #1;
      bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1;
      d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic t_reset;
      bus_read(2'd1, rd); chk("R1 ctrl", rd, 32'h0);
      bus_read(2'd2, rd); chk("R1 istat", rd, 32'h0);
      bus_read(2'd3, rd); chk("R1 ien", rd, 32'h0);
      chk("R1 irq/push/pop", {host_irq, tx_push, rx_pop}, 0);
   endtask

   task automatic t_tx;
      tx_full = 1'b0;
      bus_write(2'd0, 32'h1A5);
      chk("R2 push", s_push, 1); chk("R2 data", s_tdata, 8'hA5);
      bus_write(2'd0, 32'h0A5);
      chk("R2 no flag no push", s_push, 0);
      tx_full = 1'b1;
      bus_write(2'd0, 32'h15A);
      chk("R2 full no push", s_push, 0);
      bus_read(2'd0, rd); chk("R3 full flag", rd[8], 0);
      tx_full = 1'b0;
      bus_read(2'd0, rd); chk("R3 room flag", rd[8], 1);
   endtask

   task automatic t_rx;
      rx_data = 8'h3C; rx_empty = 1'b1;
      bus_read(2'd0, rd); chk("R4 empty read", rd, 32'h100);
      @(negedge clk); rx_empty = 1'b0;
      bus_read(2'd0, rd); chk("R4 valid read", rd, 32'h33C);
      bus_write(2'd0, 32'h200); chk("R5 pop", s_pop, 1);
      chk("R2 rx flag no push", s_push, 0);
      @(negedge clk); rx_empty = 1'b1;
      bus_write(2'd0, 32'h200); chk("R5 empty no pop", s_pop, 0);
      bus_write(2'd2, 32'h3);
   endtask

   task automatic t_irq;
      bus_write(2'd3, 32'h3);
      bus_read(2'd3, rd); chk("R8 ien", rd, 32'h3);
      @(negedge clk); rx_empty = 1'b0;
      @(posedge clk); #1;
      bus_read(2'd2, rd); chk("R6 rx valid set", rd, 32'h1);
      chk("R8 irq off w/o hen", host_irq, 0);
      bus_read(2'd1, rd); chk("R8 pend flag", rd[6], 1);
      bus_write(2'd1, 32'h20);
      chk("R8 irq on", host_irq, 1);
      bus_write(2'd2, 32'h2);
      bus_read(2'd2, rd); chk("R7 other bit kept", rd, 32'h1);
      bus_write(2'd2, 32'h1);
      bus_read(2'd2, rd); chk("R7 cleared", rd, 32'h0);
      chk("R8 irq drops", host_irq, 0);
      @(negedge clk); tx_empty = 1'b0;
      @(negedge clk); tx_empty = 1'b1;
      @(posedge clk); #1;
      bus_read(2'd2, rd); chk("R6 tx empty set", rd, 32'h2);
      chk("R8 irq tx", host_irq, 1);
      bus_write(2'd2, 32'h2);
      @(negedge clk); rx_empty = 1'b1;
      @(negedge clk);
      rx_empty = 1'b0;
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 32'h1;
      @(posedge clk); #1;
      bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
      bus_read(2'd2, rd); chk("R7 event beats clear", rd, 32'h1);
      bus_write(2'd2, 32'h3);
      bus_write(2'd1, 32'h0);
      rx_empty = 1'b1;
   endtask

   task automatic t_break;
      ser_out_raw = 1'b1;
      @(negedge clk); #1; chk("R9 txd follows", txd, 1);
      bus_write(2'd1, 32'h10);
      chk("R9 break low", {tx_break, txd}, 2'b10);
      bus_write(2'd1, 32'h0);
      chk("R9 break released", {tx_break, txd}, 2'b01);
   endtask

   task automatic t_ctrl;
      tx_empty = 1'b0; tx_active = 1'b0;
      bus_read(2'd1, rd); chk("R10 busy fifo", rd[7], 1);
      tx_empty = 1'b1; tx_active = 1'b1;
      bus_read(2'd1, rd); chk("R10 busy shift", rd[7], 1);
      tx_active = 1'b0;
      bus_read(2'd1, rd); chk("R10 idle", rd[7], 0);
      bus_write(2'd1, 32'hC0);
      bus_read(2'd1, rd); chk("R10 ro bits", rd, 32'h0);
      bus_write(2'd1, 32'h2);
      chk("R11 odd", parity_mode, 2);
      bus_write(2'd1, 32'hB);
      chk("R11 rsvd kept", parity_mode, 2);
      chk("R11 mode", if_mode, 2);
      bus_read(2'd1, rd); chk("R11 readback", rd, 32'hA);
      bus_write(2'd1, 32'h1);
      chk("R11 even", {if_mode, parity_mode}, 4'b0001);
   endtask

   initial begin
      fork
         begin
            repeat (3) @(posedge clk);
            @(negedge clk); rst_n = 1'b1;
            t_reset;
            t_tx;
            t_rx;
            t_irq;
            t_break;
            t_ctrl;
         end
         begin
            repeat (20000) @(posedge clk);
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule